// File: doc/BRIEF.md
# Small-Page NAND Flash Target Emulator

This block behaves like a scaled-down small-page NAND flash device, so that a host NAND controller can be tested against it. Commands, addresses and data share one 8-bit bus. The host qualifies each byte with chip enable, write strobe, read strobe, a command-latch line and an address-latch line. All of these are sampled on the emulator's own clock, so the host strobes must be held for at least one clock period on each level. A ready/busy output goes low while an internal page load, program or erase runs. Each busy time is a fixed, parameterized number of clock cycles.

The array is held in registers. Each page has a main area and a spare area, and the block count and pages per block are parameters. After reset the array holds a known pattern: byte `c` of row `r` equals `(r*PAGE_BYTES + c) mod 256`, where `PAGE_BYTES` is main plus spare. The emulator supports the following operations:
- page read with sequential output,
- page program,
- block erase,
- copy-back of the buffered page to another row,
- status read,
- identifier read.

Page 0 is preloaded into the page buffer automatically after reset. A write-protect input blocks program and erase. Chip enable going high during a read pauses the output, and the read resumes when chip enable returns low.

The bus is strobe-qualified and has no valid/ready handshake. Flow control comes only from the ready/busy line: the host must not issue anything but the status command while `rb_n` is low, and any other byte it sends then is dropped. The bus is byte-serial. Each read-strobe fall yields exactly one byte, and each write-strobe rise consumes exactly one byte.

Top module: `nand_emu`

## Requirements
- R1: A byte on `dq_i` is taken on a rising edge of `we_n` only while `ce_n` is low. With `cle` high it is a command, with `ale` high it is an address, and with neither it is program data. With `ce_n` high the byte is ignored.
- R2: Command 0x00 is followed by two address bytes, a column and then a row. After the second address byte the row is copied into the page buffer, and each later falling edge of `re_n` presents the byte at the current column on `dq_o` and then advances the column.
- R3: The read column steps past the last main byte into the spare bytes. After the last spare byte it wraps to column 0 of the same page.
- R4: `rb_n` falls in the cycle an operation starts and stays low for exactly `T_LOAD`, `T_PROG` or `T_ERASE` clock cycles for a page load, program or erase. While `rb_n` is low, only command 0x70 is accepted.
- R5: Command 0x70 selects status output. The status byte has bit 7 = `wp_n`, bit 6 = ready (1 when idle), bit 0 = fail (1 when the last program or erase was refused), and all other bits 0. Program and erase confirms also switch the output to status.
- R6: Command 0x80, then column, row and data bytes, then 0x10 programs the row. The page buffer is filled with 0xFF at 0x80. Data bytes are stored from the given column onward. The row becomes the bitwise AND of its old content and the buffer.
- R7: Command 0x60, one row byte, then 0xD0 sets every byte of every page in the block holding that row to 0xFF. The block is row / `PAGES`. Other blocks keep their content.
- R8: Command 0x8A, column, row, then 0x10 programs the current page buffer (for example, a page just read) into the given row with no data bytes. The AND rule of R6 applies.
- R9: While `wp_n` is low, a program or erase confirm leaves the array unchanged, keeps `rb_n` high and sets the status fail bit.
- R10: Raising `ce_n` during a read does not abort it. Read strobes given while `ce_n` is high do not advance the column, and output continues from the next column once `ce_n` is low again.
- R11: Command 0x90 followed by one address byte selects identifier output. The first read byte is `MFR_CODE` (default 0xA7) and the second is `DEV_CODE` (default 0x35).
- R12: After reset, row 0 is loaded into the page buffer during a `T_LOAD`-cycle busy period. Read strobes with no command then return row 0 from column 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Emulator clock; all pins are sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset (power-up) |
| ce_n | input | 1 | Chip enable, active low |
| we_n | input | 1 | Write strobe; its rising edge latches `dq_i` |
| re_n | input | 1 | Read strobe; its falling edge emits the next byte |
| cle | input | 1 | Marks the latched byte as a command |
| ale | input | 1 | Marks the latched byte as an address |
| wp_n | input | 1 | Write protect, active low |
| dq_i | input | 8 | Bus byte from the host |
| dq_o | output | 8 | Bus byte to the host |
| dq_oe | output | 1 | High while the emulator drives the bus (`ce_n` and `re_n` low) |
| rb_n | output | 1 | Ready/busy, low while an internal operation runs |

## Verification
Four properties are checked on every clock cycle by the assertions:
- A program step never turns a 0 bit into a 1.
- An erased row reads all ones at once.
- The busy counter is started only while idle, and `rb_n` is released only in the cycle after an array operation commits.
- The column stays in range and does not move while chip enable is high, and a protected confirm never drops `rb_n`.

Some properties can only be shown by the bench's scenarios:
- the exact byte values after read, program, copy-back and erase,
- the column wrap,
- the identifier sequence,
- the status encodings,
- the preload after reset,
- the exact length of each busy period.

// File: rtl/nand_pkg.sv
package nand_pkg;
  typedef enum logic [1:0] {OP_NONE, OP_LOAD, OP_PROG, OP_ERASE} op_e;
  typedef enum logic [1:0] {M_DATA, M_STATUS, M_ID} mode_e;
  typedef enum logic [2:0] {C_NONE, C_READ, C_PROG, C_COPY, C_ERASE, C_ID} cmd_e;

  localparam logic [7:0] K_READ  = 8'h00;
  localparam logic [7:0] K_PROG  = 8'h80;
  localparam logic [7:0] K_COPY  = 8'h8A;
  localparam logic [7:0] K_PCONF = 8'h10;
  localparam logic [7:0] K_ERASE = 8'h60;
  localparam logic [7:0] K_ECONF = 8'hD0;
  localparam logic [7:0] K_STAT  = 8'h70;
  localparam logic [7:0] K_ID    = 8'h90;
endpackage

// File: rtl/nand_busy.sv
module nand_busy #(
  parameter int CNT_W = 5,
  parameter int INIT  = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CNT_W-1:0] cycles,
  output logic             busy,
  output logic             done
);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= CNT_W'(INIT);
    else if (start)      cnt <= cycles;
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign busy = (cnt != '0);
  assign done = (cnt == CNT_W'(1));

  // R4: an operation is only started from the idle state
  a_r4_start_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !busy);
  // R4: busy is entered only through a start request
  a_r4_busy_needs_start: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start));
endmodule

// File: rtl/nand_array.sv
module nand_array import nand_pkg::*; #(
  parameter int PB    = 10,
  parameter int ROWS  = 16,
  parameter int PAGES = 4,
  localparam int ROW_W = $clog2(ROWS),
  localparam int PG_W  = $clog2(PAGES),
  localparam int W     = PB * 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  op_e              op,
  input  logic [ROW_W-1:0] row,
  input  logic [W-1:0]     wr_page,
  output logic [W-1:0]     rd_page
);
  logic [W-1:0] mem [ROWS];

  assign rd_page = mem[row];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int r = 0; r < ROWS; r++)
        for (int c = 0; c < PB; c++)
          mem[r][c*8 +: 8] <= 8'((r * PB + c) % 256);
    end else begin
      case (op)
        OP_PROG:  mem[row] <= mem[row] & wr_page;
        OP_ERASE: for (int p = 0; p < PAGES; p++)
                    mem[{row[ROW_W-1:PG_W], PG_W'(p)}] <= '1;
        default: ;
      endcase
    end
  end

  // R6: programming can only clear bits of the target row
  a_r6_and_only: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_PROG) |=> ((rd_page & ~$past(rd_page)) == '0));
  // R7: the addressed row reads all ones right after an erase
  a_r7_erased_ones: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_ERASE) |=> (rd_page == '1));
endmodule

// File: rtl/nand_emu.sv
module nand_emu import nand_pkg::*; #(
  parameter int MAIN_BYTES  = 8,
  parameter int SPARE_BYTES = 2,
  parameter int PAGES       = 4,
  parameter int BLKS        = 4,
  parameter int T_LOAD      = 4,
  parameter int T_PROG      = 12,
  parameter int T_ERASE     = 20,
  parameter logic [7:0] MFR_CODE = 8'hA7,
  parameter logic [7:0] DEV_CODE = 8'h35
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ce_n,
  input  logic       we_n,
  input  logic       re_n,
  input  logic       cle,
  input  logic       ale,
  input  logic       wp_n,
  input  logic [7:0] dq_i,
  output logic [7:0] dq_o,
  output logic       dq_oe,
  output logic       rb_n
);
  localparam int PB    = MAIN_BYTES + SPARE_BYTES;
  localparam int ROWS  = PAGES * BLKS;
  localparam int ROW_W = $clog2(ROWS);
  localparam int COL_W = $clog2(PB);
  localparam int TMAX  = (T_ERASE > T_PROG) ? ((T_ERASE > T_LOAD) ? T_ERASE : T_LOAD)
                                            : ((T_PROG > T_LOAD) ? T_PROG : T_LOAD);
  localparam int CNT_W = $clog2(TMAX + 1);

  logic             we_q, re_q, we_rise, re_fall;
  logic [PB*8-1:0]  pbuf, rd_page;
  logic [COL_W-1:0] col, col_nxt, col_adr;
  logic [ROW_W-1:0] row;
  cmd_e             cmd;
  mode_e            mode;
  op_e              op_pend, start_op, arr_op;
  logic [1:0]       addr_left;
  logic             fail, id_sel, busy, bsy_done, bsy_start, confirm_ok;
  logic [CNT_W-1:0] cycles;
  logic [7:0]       dout, stat;

  assign we_rise = we_n & ~we_q & ~ce_n;
  assign re_fall = ~re_n & re_q & ~ce_n;
  assign col_nxt = (col == COL_W'(PB - 1)) ? '0 : col + 1'b1;
  assign col_adr = (dq_i < 8'(PB)) ? dq_i[COL_W-1:0] : '0;
  assign stat    = {wp_n, ~busy, 5'b0, fail};
  assign confirm_ok = (addr_left == 2'd0) &&
                      (((dq_i == K_PCONF) && (cmd == C_PROG || cmd == C_COPY)) ||
                       ((dq_i == K_ECONF) && (cmd == C_ERASE)));

  always_comb begin
    start_op = OP_NONE;
    if (we_rise && !busy) begin
      if (cle && confirm_ok && wp_n)
        start_op = (cmd == C_ERASE) ? OP_ERASE : OP_PROG;
      else if (!cle && ale && cmd == C_READ && addr_left == 2'd1)
        start_op = OP_LOAD;
    end
  end
  assign bsy_start = (start_op != OP_NONE);
  assign cycles = (start_op == OP_ERASE) ? CNT_W'(T_ERASE) :
                  (start_op == OP_PROG)  ? CNT_W'(T_PROG) : CNT_W'(T_LOAD);
  assign arr_op = bsy_done ? op_pend : OP_NONE;

  nand_busy #(.CNT_W(CNT_W), .INIT(T_LOAD)) i_busy (
    .clk(clk), .rst_n(rst_n), .start(bsy_start), .cycles(cycles),
    .busy(busy), .done(bsy_done));

  nand_array #(.PB(PB), .ROWS(ROWS), .PAGES(PAGES)) i_array (
    .clk(clk), .rst_n(rst_n), .op(arr_op), .row(row),
    .wr_page(pbuf), .rd_page(rd_page));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      we_q <= 1'b1; re_q <= 1'b1;
      pbuf <= '1; col <= '0; row <= '0;
      cmd <= C_NONE; mode <= M_DATA; op_pend <= OP_LOAD;
      addr_left <= '0; fail <= 1'b0; id_sel <= 1'b0; dout <= '0;
    end else begin
      we_q <= we_n;
      re_q <= re_n;
      if (bsy_start) begin
        op_pend <= start_op;
        fail    <= 1'b0;
      end
      if (bsy_done && op_pend == OP_LOAD) pbuf <= rd_page;
      if (we_rise) begin
        if (cle) begin
          if (dq_i == K_STAT) mode <= M_STATUS;
          else if (!busy) begin
            if (confirm_ok) begin
              cmd  <= C_NONE;
              mode <= M_STATUS;
              fail <= ~wp_n;
            end else begin
              case (dq_i)
                K_READ:  begin cmd <= C_READ;  addr_left <= 2'd2; mode <= M_DATA; end
                K_PROG:  begin cmd <= C_PROG;  addr_left <= 2'd2; pbuf <= '1; end
                K_COPY:  begin cmd <= C_COPY;  addr_left <= 2'd2; end
                K_ERASE: begin cmd <= C_ERASE; addr_left <= 2'd1; end
                K_ID:    begin cmd <= C_ID;    addr_left <= 2'd1; mode <= M_ID; id_sel <= 1'b0; end
                default: cmd <= C_NONE;
              endcase
            end
          end
        end else if (ale) begin
          if (!busy && addr_left != 2'd0) begin
            addr_left <= addr_left - 1'b1;
            if (cmd != C_ID) begin
              if (cmd == C_ERASE || addr_left == 2'd1) row <= dq_i[ROW_W-1:0];
              else                                     col <= col_adr;
            end
          end
        end else if (!busy && cmd == C_PROG && addr_left == 2'd0) begin
          pbuf[8*int'(col) +: 8] <= dq_i;
          col <= col_nxt;
        end
      end
      if (re_fall) begin
        case (mode)
          M_DATA: if (!busy) begin
            dout <= pbuf[8*int'(col) +: 8];
            col  <= col_nxt;
          end
          M_STATUS: dout <= stat;
          default: begin
            dout   <= id_sel ? DEV_CODE : MFR_CODE;
            id_sel <= ~id_sel;
          end
        endcase
      end
    end
  end

  assign dq_o  = dout;
  assign dq_oe = ~ce_n & ~re_n;
  assign rb_n  = ~busy;

  // R3: the column never leaves the page
  a_r3_col_in_page: assert property (@(posedge clk) disable iff (!rst_n)
    col < COL_W'(PB));
  // R10: strobes seen with chip enable high leave the column alone
  a_r10_ce_high_holds_col: assert property (@(posedge clk) disable iff (!rst_n)
    $past(ce_n) |-> $stable(col));
  // R4: ready returns only after an array operation has committed
  a_r4_release_after_op: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rb_n) |-> $past(arr_op != OP_NONE));
  // R9: a confirm under write protect leaves the device ready
  a_r9_protected_stays_ready: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(we_rise && cle && confirm_ok && !busy) && !$past(wp_n)) |-> rb_n);
endmodule

// File: tb/test_nand_emu.sv
module test_nand_emu;
  localparam int T_LOAD  = 4;
  localparam int T_PROG  = 12;
  localparam int T_ERASE = 20;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ce_n = 1'b0, we_n = 1'b1, re_n = 1'b1, cle = 1'b0, ale = 1'b0, wp_n = 1'b1;
  logic [7:0] dq_i = '0, dq_o;
  logic dq_oe, rb_n;
  int n_cmp = 0, n_bad = 0;

  always #4 clk = ~clk;

  nand_emu #(.MAIN_BYTES(8), .SPARE_BYTES(2), .PAGES(4), .BLKS(4),
             .T_LOAD(T_LOAD), .T_PROG(T_PROG), .T_ERASE(T_ERASE),
             .MFR_CODE(8'hA7), .DEV_CODE(8'h35)) i_nand_emu (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .re_n(re_n),
    .cle(cle), .ale(ale), .wp_n(wp_n), .dq_i(dq_i), .dq_o(dq_o),
    .dq_oe(dq_oe), .rb_n(rb_n));

  // {row, column, first byte, second byte}; pattern byte = row*10 + column
  localparam logic [31:0] VEC [6] = '{
    {8'd0,  8'd0, 8'h00, 8'h01},
    {8'd1,  8'd3, 8'h0D, 8'h0E},
    {8'd5,  8'd9, 8'h3B, 8'h32},
    {8'd15, 8'd9, 8'h9F, 8'h96},
    {8'd7,  8'd0, 8'h46, 8'h47},
    {8'd10, 8'd4, 8'h68, 8'h69}
  };

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic chk_n(input string tag, input int got, input int exp);
    n_cmp++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  task automatic strobe(input logic c, input logic a, input logic [7:0] b);
    @(negedge clk); cle = c; ale = a; dq_i = b; we_n = 1'b0;
    @(negedge clk); we_n = 1'b1;
    @(negedge clk); cle = 1'b0; ale = 1'b0;
  endtask

  task automatic cmd(input logic [7:0] b);  strobe(1'b1, 1'b0, b); endtask
  task automatic addr(input logic [7:0] b); strobe(1'b0, 1'b1, b); endtask
  task automatic din(input logic [7:0] b);  strobe(1'b0, 1'b0, b); endtask

  task automatic rd(output logic [7:0] v);
    @(negedge clk); re_n = 1'b0;
    @(negedge clk); v = dq_o; re_n = 1'b1;
  endtask

  task automatic wait_rdy(output int n);
    n = 0;
    while (!rb_n) begin n++; @(negedge clk); end
  endtask

  task automatic read_page(input logic [7:0] r, input logic [7:0] c);
    int n;
    cmd(8'h00); addr(c); addr(r); wait_rdy(n);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_bad++;
    $display("FAIL R4 watchdog expired: got hang expected completion");
    summary();
  end

  initial begin
    logic [7:0] v;
    int n;
    repeat (3) @(negedge clk);
    chk("R12 rb_n low in reset", {7'b0, rb_n}, 8'h00);
    rst_n = 1'b1;
    // R12/R4: preload busy period after reset
    wait_rdy(n); chk_n("R12 preload busy cycles", n, T_LOAD);
    rd(v); chk("R12 preload byte 0", v, 8'h00);
    rd(v); chk("R12 preload byte 1", v, 8'h01);

    // R2/R3 vector table: page reads with sequential output and wrap
    for (int i = 0; i < 6; i++) begin
      cmd(8'h00); addr(VEC[i][23:16]); addr(VEC[i][31:24]);
      wait_rdy(n); chk_n("R4 load busy cycles", n, T_LOAD);
      rd(v); chk("R2 first byte", v, VEC[i][15:8]);
      rd(v); chk("R3 next byte or wrap", v, VEC[i][7:0]);
    end

    // R11 identifier
    cmd(8'h90); addr(8'h00);
    rd(v); chk("R11 maker code", v, 8'hA7);
    rd(v); chk("R11 device code", v, 8'h35);

    // R6 program row 2 from column 0, R5 status during and after busy
    cmd(8'h80); addr(8'h00); addr(8'h02); din(8'h0F); din(8'hF0); cmd(8'h10);
    rd(v); chk("R5 status busy", v, 8'h80);
    wait_rdy(n);
    rd(v); chk("R5 status ready pass", v, 8'hC0);
    read_page(8'd2, 8'd0);
    rd(v); chk("R6 and byte 0", v, 8'h04);
    rd(v); chk("R6 and byte 1", v, 8'h10);
    rd(v); chk("R6 unwritten byte kept", v, 8'h16);

    // R10 chip enable high pauses the read; R1 bytes ignored with ce_n high
    read_page(8'd3, 8'd0);
    rd(v); chk("R10 first byte", v, 8'h1E);
    @(negedge clk); ce_n = 1'b1;
    rd(v); rd(v);
    cmd(8'h70);
    @(negedge clk); ce_n = 1'b0;
    rd(v); chk("R10 R1 read resumes", v, 8'h1F);

    // R8 copy-back of row 3 buffer into row 8
    read_page(8'd3, 8'd0);
    cmd(8'h8A); addr(8'h00); addr(8'h08); cmd(8'h10);
    wait_rdy(n); chk_n("R8 R4 copy busy cycles", n, T_PROG);
    read_page(8'd8, 8'd0);
    rd(v); chk("R8 copied byte 0", v, 8'h10);
    rd(v); chk("R8 copied byte 1", v, 8'h11);

    // R7 erase block 1 (rows 4..7) addressed via row 5
    cmd(8'h60); addr(8'h05); cmd(8'hD0);
    wait_rdy(n); chk_n("R4 erase busy cycles", n, T_ERASE);
    read_page(8'd4, 8'd0);
    rd(v); chk("R7 row 4 byte 0", v, 8'hFF);
    rd(v); chk("R7 row 4 byte 1", v, 8'hFF);
    read_page(8'd7, 8'd9);
    rd(v); chk("R7 row 7 spare", v, 8'hFF);
    rd(v); chk("R7 row 7 wrapped", v, 8'hFF);
    read_page(8'd8, 8'd0);
    rd(v); chk("R7 other block kept", v, 8'h10);
    read_page(8'd3, 8'd0);
    rd(v); chk("R7 lower block kept", v, 8'h1E);

    // R9 write protect
    wp_n = 1'b0;
    cmd(8'h70);
    rd(v); chk("R9 R5 status protected", v, 8'h40);
    cmd(8'h60); addr(8'h00); cmd(8'hD0);
    wait_rdy(n); chk_n("R9 erase no busy", n, 0);
    rd(v); chk("R9 status fail", v, 8'h41);
    cmd(8'h80); addr(8'h00); addr(8'h01); din(8'h00); cmd(8'h10);
    wait_rdy(n); chk_n("R9 program no busy", n, 0);
    wp_n = 1'b1;
    read_page(8'd1, 8'd0);
    rd(v); chk("R9 row 1 unchanged", v, 8'h0A);
    read_page(8'd0, 8'd0);
    rd(v); chk("R9 row 0 unchanged", v, 8'h00);

    summary();
  end
endmodule